// File: doc/BRIEF.md
# Parallel-Bin Correlating Pulse Receiver with Finger Vote

This block is the bit-recovery core of a coherent impulse-radio receiver. Each clock it takes a word of `LANES` parallel ADC samples covering one slice of time. It splits those lanes into a set of time bins, each one synchronization step wide. Every bin runs its own chain. Two correlators, one for a logic-one template and one for a logic-zero template, feed an energy comparison that makes a chip decision. A despreader then folds the chips of one bit into a bit decision. Last comes a start-of-frame delimiter correlator over the recent bit history.

Bins whose delimiter correlator fires become fingers and stay fingers until a new search. Once at least one finger exists, every later bit is formed by a majority vote over the fingers' bit decisions. It is emitted with a one-cycle valid strobe. Chip length, processing gain, bin count and delimiter threshold are runtime inputs. A search pulse restarts chip and bit timing, so that a new configuration or a new frame starts on a clean boundary.

Top module: `mbr_top`

## Requirements
- R1: `mode_i` = m selects `LANES >> m` active bins. Bin b takes the lanes l with `(l >> m) == b`, where lane l is `samples_i[l*SW +: SW]`, a signed two's-complement value. An inactive bin never becomes a finger.
- R2: For each chip, a bin adds up its lanes over the chip's `chip_len_i` cycles. The chip decision is 1 when the total is greater than zero, which means the one-template correlation beats the zero-template correlation, and 0 otherwise.
- R3: For chip k of a bit (k counted from 0), the bin forms the chip decision XOR bit k of the spreading word 8'hB2. The bit decision is 1 only when more than half of the processing-gain estimates are 1.
- R4: On each bit, the bin shifts its bit decision into an 8-bit history at bit 0, with older bits moving up. When the number of positions agreeing with the delimiter 8'hE5 is at least `sfd_thr_i`, the bin becomes a finger. A finger stays set until the next search.
- R5: The output bit is the majority of the fingers' bit decisions.
- R6: When the fingers' vote is tied, the output bit is the decision of the lowest-index finger.
- R7: `bit_valid_o` pulses for one cycle for a bit only if a finger existed before that bit's delimiter update. The bit that completes the delimiter is therefore not output. Output appears two clock edges after the bit's last sample cycle.
- R8: `search_i` clears all fingers, the delimiter histories and any bit in flight. The cycle after it is chip 0, cycle 0 of a new bit. Samples presented with `search_i` are discarded.
- R9: `sync_o` is high exactly when at least one finger is set. It changes on the same edge as the `bit_valid_o` of the bit that caused the change.
- R10: A `chip_len_i` of 0 acts as 1. A `gain_i` of 0 acts as 1, and a value above 8 acts as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samples_i | input | LANES*SW | Parallel signed sample word, lane 0 in the low bits |
| mode_i | input | MODE_W | Bin-count select, bins = LANES >> mode_i |
| chip_len_i | input | CL_W | Clock cycles per chip |
| gain_i | input | PG_W | Chips per bit (processing gain) |
| sfd_thr_i | input | THR_W | Delimiter agreement threshold |
| search_i | input | 1 | Start a new frame search |
| bit_o | output | 1 | Voted payload bit |
| bit_valid_o | output | 1 | One-cycle strobe for bit_o |
| sync_o | output | 1 | At least one finger synchronized |

## Verification
A bit's decision is registered on the edge that takes its last sample cycle. The voted bit and its valid strobe come out on the following edge, so they are due two edges after that cycle. Any finger change, and with it `sync_o`, lands on that same second edge. A search takes effect on the single edge that samples it. The bench drives on falling edges and counts cycles. For each bit it writes the expected strobe, bit and sync state into a small ring slot indexed by the cycle two steps ahead, and it compares that slot on the falling edge where it is due. On every other falling edge it requires the strobe to be low and the sync flag unchanged.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int unsigned DLM_LEN  = 8;
  localparam logic [DLM_LEN-1:0] DLM_WORD = 8'hE5;
  localparam int unsigned GAIN_MAX = 8;
  localparam logic [GAIN_MAX-1:0] SPREAD_WORD = 8'hB2;
endpackage

// File: rtl/mbr_timing.sv
module mbr_timing #(
  parameter  int unsigned CL_W   = 3,
  parameter  int unsigned PG_W   = 4,
  parameter  int unsigned PG_MAX = 8,
  localparam int unsigned CI_W   = $clog2(PG_MAX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            search_i,
  input  logic [CL_W-1:0] chip_len_i,
  input  logic [PG_W-1:0] gain_i,
  output logic            chip_first_o,
  output logic            chip_end_o,
  output logic [CI_W-1:0] chip_idx_o,
  output logic            bit_end_o,
  output logic            bit_stb_o,
  output logic [PG_W-1:0] pg_eff_o
);
  logic [CL_W-1:0] cl_eff, cyc_q;
  logic [CI_W-1:0] chip_q;
  logic            stb_q;

  always_comb begin
    cl_eff = (chip_len_i == '0) ? CL_W'(1) : chip_len_i;
    if (gain_i == '0)                 pg_eff_o = PG_W'(1);
    else if (gain_i > PG_W'(PG_MAX))  pg_eff_o = PG_W'(PG_MAX);
    else                              pg_eff_o = gain_i;
  end

  assign chip_first_o = (cyc_q == '0);
  assign chip_end_o   = (cyc_q == cl_eff - CL_W'(1));
  assign bit_end_o    = chip_end_o && (PG_W'(chip_q) == pg_eff_o - PG_W'(1));
  assign chip_idx_o   = chip_q;
  assign bit_stb_o    = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      chip_q <= '0;
      stb_q  <= 1'b0;
    end else if (search_i) begin
      cyc_q  <= '0;
      chip_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= bit_end_o;
      if (chip_end_o) begin
        cyc_q  <= '0;
        chip_q <= bit_end_o ? '0 : chip_q + CI_W'(1);
      end else begin
        cyc_q <= cyc_q + CL_W'(1);
      end
    end
  end
endmodule

// File: rtl/mbr_bin.sv
module mbr_bin #(
  parameter  int unsigned LANES    = 16,
  parameter  int unsigned SW       = 8,
  parameter  int unsigned MODE_W   = 2,
  parameter  int unsigned CL_W     = 3,
  parameter  int unsigned PG_W     = 4,
  parameter  int unsigned PG_MAX   = 8,
  parameter  int unsigned DLM_LEN  = 8,
  parameter  int unsigned THR_W    = 4,
  parameter  int unsigned BIN_IDX  = 0,
  parameter  logic [PG_MAX-1:0]  SPREAD = '0,
  parameter  logic [DLM_LEN-1:0] DLM    = '0,
  localparam int unsigned CI_W  = $clog2(PG_MAX),
  localparam int unsigned LS_W  = SW + $clog2(LANES),
  localparam int unsigned ACC_W = LS_W + CL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES*SW-1:0] samples_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               search_i,
  input  logic               chip_first_i,
  input  logic               chip_end_i,
  input  logic               bit_end_i,
  input  logic               bit_stb_i,
  input  logic [CI_W-1:0]    chip_idx_i,
  input  logic [PG_W-1:0]    pg_eff_i,
  input  logic [THR_W-1:0]   sfd_thr_i,
  output logic               bit_dec_o,
  output logic               finger_o
);
  logic signed [LS_W-1:0]  lane_sum;
  logic signed [ACC_W-1:0] acc_q, chip_total;
  logic                    chip_dec, est, bit_dec;
  logic [PG_W-1:0]         cnt_q, tot;
  logic [DLM_LEN-1:0]      hist_q, hist_nx;
  logic [THR_W-1:0]        agree;
  logic                    active, match;

  // correlate against +1 (one) and -1 (zero) templates: energy compare reduces to sign of sum
  always_comb begin
    lane_sum = '0;
    for (int l = 0; l < LANES; l++)
      if ((l >> mode_i) == BIN_IDX)
        lane_sum = lane_sum + LS_W'($signed(samples_i[l*SW +: SW]));
  end

  assign chip_total = chip_first_i ? ACC_W'(lane_sum) : acc_q + ACC_W'(lane_sum);
  assign chip_dec   = chip_total > 0;
  assign est        = chip_dec ^ SPREAD[chip_idx_i];
  assign tot        = ((chip_idx_i == '0) ? '0 : cnt_q) + PG_W'(est);
  assign bit_dec    = {tot, 1'b0} > {1'b0, pg_eff_i};

  assign hist_nx = {hist_q[DLM_LEN-2:0], bit_dec_o};
  assign agree   = THR_W'($countones(~(hist_nx ^ DLM)));
  assign match   = agree >= sfd_thr_i;
  assign active  = BIN_IDX < (LANES >> mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      bit_dec_o <= 1'b0;
    end else begin
      acc_q <= chip_total;
      if (chip_end_i) begin
        cnt_q <= tot;
        if (bit_end_i) bit_dec_o <= bit_dec;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= '0;
      finger_o <= 1'b0;
    end else if (search_i) begin
      hist_q   <= '0;
      finger_o <= 1'b0;
    end else if (!active) begin
      finger_o <= 1'b0;
    end else if (bit_stb_i) begin
      hist_q <= hist_nx;
      if (match) finger_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mbr_vote.sv
module mbr_vote #(
  parameter int unsigned NB = 16
) (
  input  logic [NB-1:0] fingers_i,
  input  logic [NB-1:0] bits_i,
  output logic          vote_o
);
  int   ones, n;
  logic first;

  always_comb begin
    ones  = $countones(fingers_i & bits_i);
    n     = $countones(fingers_i);
    first = 1'b0;
    for (int b = NB - 1; b >= 0; b--)
      if (fingers_i[b]) first = bits_i[b];
    if (2 * ones > n)      vote_o = 1'b1;
    else if (2 * ones < n) vote_o = 1'b0;
    else                   vote_o = first;
  end
endmodule

// File: rtl/mbr_top.sv
module mbr_top
  import mbr_pkg::*;
#(
  parameter  int unsigned LANES  = 16,
  parameter  int unsigned SW     = 8,
  parameter  int unsigned CL_W   = 3,
  localparam int unsigned MODE_W = $clog2($clog2(LANES)),
  localparam int unsigned PG_W   = $clog2(GAIN_MAX + 1),
  localparam int unsigned THR_W  = $clog2(DLM_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*SW-1:0] samples_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [CL_W-1:0]     chip_len_i,
  input  logic [PG_W-1:0]     gain_i,
  input  logic [THR_W-1:0]    sfd_thr_i,
  input  logic                search_i,
  output logic                bit_o,
  output logic                bit_valid_o,
  output logic                sync_o
);
  localparam int unsigned CI_W = $clog2(GAIN_MAX);

  logic            chip_first, chip_end, bit_end, bit_stb;
  logic [CI_W-1:0] chip_idx;
  logic [PG_W-1:0] pg_eff;
  logic [LANES-1:0] finger_q, bit_dec;
  logic            vote;

  mbr_timing #(.CL_W(CL_W), .PG_W(PG_W), .PG_MAX(GAIN_MAX)) u_tim (
    .clk_i, .rst_ni, .search_i, .chip_len_i, .gain_i,
    .chip_first_o(chip_first), .chip_end_o(chip_end), .chip_idx_o(chip_idx),
    .bit_end_o(bit_end), .bit_stb_o(bit_stb), .pg_eff_o(pg_eff)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bin
    mbr_bin #(
      .LANES(LANES), .SW(SW), .MODE_W(MODE_W), .CL_W(CL_W), .PG_W(PG_W),
      .PG_MAX(GAIN_MAX), .DLM_LEN(DLM_LEN), .THR_W(THR_W), .BIN_IDX(b),
      .SPREAD(SPREAD_WORD), .DLM(DLM_WORD)
    ) u_bin (
      .clk_i, .rst_ni, .samples_i, .mode_i, .search_i,
      .chip_first_i(chip_first), .chip_end_i(chip_end), .bit_end_i(bit_end),
      .bit_stb_i(bit_stb), .chip_idx_i(chip_idx), .pg_eff_i(pg_eff),
      .sfd_thr_i, .bit_dec_o(bit_dec[b]), .finger_o(finger_q[b])
    );
  end

  mbr_vote #(.NB(LANES)) u_vote (.fingers_i(finger_q), .bits_i(bit_dec), .vote_o(vote));

  assign sync_o = |finger_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      bit_valid_o <= bit_stb && sync_o && !search_i;
      if (bit_stb) bit_o <= vote;
    end
  end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              search_i,
  input logic              valid_i,
  input logic              sync_i,
  input logic [LANES-1:0]  fingers_i,
  input logic              bit_end_i
);
  logic [MODE_W-1:0] mode_q;
  logic [LANES-1:0]  mask;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_i;

  always_comb
    for (int b = 0; b < LANES; b++) mask[b] = b < (LANES >> mode_q);

  a_r1_inactive_no_finger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fingers_i & ~mask) == '0);
  a_r7_valid_needs_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> sync_i);
  a_r7_valid_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(bit_end_i, 2));
  a_r8_search_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_i |=> (!sync_i && !valid_i));
  a_r4_finger_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_i) |-> ($past(search_i) || $past(mode_i) != $past(mode_q)));
endmodule

bind mbr_top mbr_checker #(.LANES(LANES), .MODE_W(MODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .search_i(search_i),
  .valid_i(bit_valid_o), .sync_i(sync_o), .fingers_i(finger_q), .bit_end_i(bit_end)
);

// File: tb/sim_mbr_top.sv
module sim_mbr_top;
  localparam int LANES = 16;
  localparam int SW    = 8;
  localparam logic [7:0] SPREAD = 8'hB2;
  localparam logic [7:0] DLM    = 8'hE5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LANES*SW-1:0] samples = '0;
  logic [1:0] mode_s = '0;
  logic [2:0] cl_s = 3'd1;
  logic [3:0] pg_s = 4'd1;
  logic [3:0] thr_s = 4'd8;
  logic search = 1'b0;
  logic bit_o, bit_valid, sync_o;

  always #4 clk = ~clk;

  mbr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .samples_i(samples), .mode_i(mode_s),
    .chip_len_i(cl_s), .gain_i(pg_s), .sfd_thr_i(thr_s), .search_i(search),
    .bit_o(bit_o), .bit_valid_o(bit_valid), .sync_o(sync_o)
  );

  int vecs = 0, fails = 0, cyc = 0;
  bit done = 0;
  int m_mode, m_nb, m_cl, m_pg, m_thr;
  logic [15:0] m_fing = '0;
  logic [7:0]  m_hist [16];
  logic sync_vis = 1'b0;
  logic   s_pend [4];
  logic   s_v [4];
  logic   s_b [4];
  logic   s_s [4];
  string  s_tag [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int eff_cl(input int raw); return (raw == 0) ? 1 : raw; endfunction
  function automatic int eff_pg(input int raw);
    return (raw == 0) ? 1 : (raw > 8) ? 8 : raw;
  endfunction

  task automatic check_slot();
    int i = cyc & 3;
    if (s_pend[i]) begin
      chk(bit_valid == s_v[i], "R7", int'(bit_valid), int'(s_v[i]));
      if (s_v[i]) chk(bit_o == s_b[i], s_tag[i], int'(bit_o), int'(s_b[i]));
      sync_vis = s_s[i];
      s_pend[i] = 1'b0;
    end else begin
      chk(!bit_valid, "R7", int'(bit_valid), 0);
    end
    chk(sync_o == sync_vis, "R9", int'(sync_o), int'(sync_vis));
  endtask

  task automatic drive(input logic [LANES*SW-1:0] s);
    @(negedge clk);
    check_slot();
    search  = 1'b0;
    samples = s;
    cyc++;
  endtask

  // R8: search with new configuration; anything in flight is dropped
  task automatic do_search(input int md, input int cl_raw, input int pg_raw, input int thr);
    @(negedge clk);
    check_slot();
    mode_s = 2'(md); cl_s = 3'(cl_raw); pg_s = 4'(pg_raw); thr_s = 4'(thr);
    search = 1'b1;
    samples = {LANES*SW{1'b1}};
    for (int i = 0; i < 4; i++) if (s_pend[i]) begin s_v[i] = 1'b0; s_s[i] = 1'b0; end
    sync_vis = 1'b0;
    m_mode = md; m_nb = LANES >> md; m_cl = eff_cl(cl_raw); m_pg = eff_pg(pg_raw); m_thr = thr;
    m_fing = '0;
    for (int b = 0; b < 16; b++) m_hist[b] = '0;
    cyc++;
  endtask

  task automatic send_bit(input logic tx, input logic [15:0] aligned,
                          input logic [15:0] corrupt, input int pchip, input string tag);
    int ones [16];
    int sums [16];
    logic [15:0] bitd, flip;
    logic [LANES*SW-1:0] s;
    int n, v1, first, due, agree, val;
    logic vb;
    for (int b = 0; b < 16; b++) ones[b] = 0;
    for (int k = 0; k < m_pg; k++) begin
      for (int b = 0; b < 16; b++) begin
        sums[b] = 0;
        flip[b] = ($urandom_range(0, 99) < pchip);
      end
      for (int c = 0; c < m_cl; c++) begin
        for (int l = 0; l < LANES; l++) begin
          int b = l >> m_mode;
          if (aligned[b]) begin
            val = (tx ^ SPREAD[k] ^ corrupt[b] ^ flip[b]) ? 50 : -50;
            val += int'($urandom_range(0, 40)) - 20;
          end else begin
            val = int'($urandom_range(0, 120)) - 60;
          end
          s[l*SW +: SW] = 8'(val);
          sums[b] += val;
        end
        drive(s);
      end
      for (int b = 0; b < 16; b++) ones[b] += int'((sums[b] > 0) ^ SPREAD[k]);
    end
    for (int b = 0; b < 16; b++) bitd[b] = (2 * ones[b] > m_pg);
    n = 0; v1 = 0; first = -1;
    for (int b = 0; b < 16; b++)
      if (m_fing[b]) begin
        n++; v1 += int'(bitd[b]);
        if (first < 0) first = int'(bitd[b]);
      end
    if (2 * v1 > n) vb = 1'b1;
    else if (2 * v1 < n) vb = 1'b0;
    else vb = (first == 1);
    due = (cyc + 1) & 3;
    s_pend[due] = 1'b1;
    s_v[due]    = (n > 0);
    s_b[due]    = vb;
    s_tag[due]  = (n > 0 && 2 * v1 == n) ? "R6" : tag;
    for (int b = 0; b < m_nb; b++) begin
      m_hist[b] = {m_hist[b][6:0], bitd[b]};
      agree = $countones(~(m_hist[b] ^ DLM));
      if (agree >= m_thr) m_fing[b] = 1'b1;
    end
    s_s[due] = |m_fing;
  endtask

  task automatic send_frame(input logic [15:0] aligned, input int npay, input int pbin,
                            input int pchip, input int errpos, input string tag);
    for (int i = 0; i < 8; i++)
      send_bit(DLM[7-i] ^ (i == errpos), aligned, '0, 0, tag);
    for (int i = 0; i < npay; i++) begin
      logic [15:0] cor;
      for (int b = 0; b < 16; b++) cor[b] = ($urandom_range(0, 99) < pbin);
      send_bit(1'($urandom), aligned, cor, pchip, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin s_pend[i] = 0; s_v[i] = 0; s_b[i] = 0; s_s[i] = 0; s_tag[i] = ""; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_o == 1'b0, "R9", int'(sync_o), 0);
    chk(bit_valid == 1'b0, "R7", int'(bit_valid), 0);
    chk(bit_o == 1'b0, "R7", int'(bit_o), 0);

    // 16 bins, three aligned, one sometimes wrong: R5 majority
    do_search(0, 2, 4, 8);
    send_frame(16'h0038, 12, 30, 0, -1, "R5");
    // chips flipped inside a bit, gain 8: R3 despreading
    do_search(1, 1, 8, 8);
    send_frame(16'h0006, 12, 0, 20, -1, "R3");
    // longer chips with noisy accumulation: R2
    do_search(2, 5, 2, 8);
    send_frame(16'h0002, 10, 0, 0, -1, "R2");
    // two fingers, one corrupted: ties resolve to lowest finger (R6)
    do_search(3, 1, 1, 8);
    send_frame(16'h0003, 16, 50, 0, -1, "R6");
    // delimiter with one bit wrong, threshold 7: R4
    do_search(1, 2, 3, 7);
    send_frame(16'h00A0, 10, 0, 0, 3, "R4");
    // same error with threshold 8: no finger expected
    do_search(1, 2, 3, 8);
    send_frame(16'h00A0, 6, 0, 0, 3, "R4");
    // zero chip length and gain, then gain above limit: R10
    do_search(2, 0, 0, 8);
    send_frame(16'h0004, 8, 0, 0, -1, "R10");
    do_search(2, 1, 12, 8);
    send_frame(16'h0001, 8, 0, 10, -1, "R10");
    // noise only: no valid unless a bin matches by chance (R7)
    do_search(0, 1, 2, 8);
    send_frame(16'h0000, 8, 0, 0, -1, "R7");
    // search in the middle of a frame clears sync: R8
    do_search(1, 1, 2, 8);
    send_frame(16'h0010, 3, 0, 0, -1, "R8");
    do_search(1, 1, 2, 8);
    @(negedge clk);
    chk(sync_o == 1'b0, "R8", int'(sync_o), 0);
    cyc++;
    check_slot();
    // restart timing after the idle cycle above
    do_search(1, 1, 2, 8);
    send_frame(16'h00F0, 6, 20, 0, -1, "R8");
    // random configurations over all bin counts: R1
    for (int t = 0; t < 14; t++) begin
      int md = $urandom_range(0, 3);
      logic [15:0] al = 16'($urandom) & 16'((32'h1 << (LANES >> md)) - 1);
      do_search(md, $urandom_range(1, 4), $urandom_range(1, 8), $urandom_range(6, 8));
      send_frame(al, $urandom_range(4, 12), 25, 10, -1, "R1");
    end
    do_search(0, 1, 1, 8);
    repeat (3) drive('0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule